// File: doc/BRIEF.md
# Streaming Radix-2 Walsh–Hadamard Transform Engine

The block computes a 32-point Walsh–Hadamard transform on a stream of signed samples. Frames of 32 samples enter one per cycle under a valid strobe, with a last flag on the final sample of each frame. The block emits the 32 unscaled transform coefficients in natural (Sylvester) order, one per cycle, with its own valid and last flags.

The engine is a chain of five identical stages. Each stage writes its incoming frame into four memory banks of eight words each. It then reads pairs of words that sit half a frame apart and emits their sum followed by their difference. Every stage uses the same read and write pattern, so no stage spends a cycle reordering data. The natural-order result falls out of the fifth stage directly. The word grows by one bit per stage: 8-bit signed samples become 13-bit signed coefficients.

Frames may follow one another with no idle cycle between them, or with any number of idle cycles. Within a frame the valid strobe must stay high for all 32 samples.

Top module: `wht_stream`

## Requirements
- R1: For an input frame x[0..31], output coefficient j equals the sum over k of x[k], negated when the bit count of (j AND k) is odd. Coefficients leave in ascending j order and carry no scaling.
- R2: out_last is high exactly with coefficient 31 of each frame and low otherwise. in_last must accompany only sample 31 of a frame.
- R3: Coefficient j appears on the outputs 89 clock edges after the edge that captured input sample j of the same frame. out_valid stays high for 32 consecutive cycles per frame.
- R4: Frames sent back to back, with no idle cycle between them, are all transformed correctly. Their coefficient runs follow one another with no gap.
- R5: out_valid is low in every cycle that does not carry a scheduled coefficient, including during idle gaps between frames.
- R6: Full-scale inputs produce exact results without wrap-around. An all -128 frame gives -4096 at coefficient 0, and an all 127 frame gives 4064 at coefficient 0.
- R7: While reset is applied, and after it until the first frame's latency has elapsed, out_valid and out_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample strobe; held high for all 32 samples of a frame |
| in_last | input | 1 | Marks sample 31 of a frame |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | Coefficient strobe |
| out_last | output | 1 | Marks coefficient 31 |
| out_data | output | 13 | Signed transform coefficient |

## Verification
The bench targets the index pairing and the sign pattern. A stage that paired the wrong addresses, or swapped sum and difference, would scramble the coefficients of a ramp or a single impulse. Full-scale constant and alternating frames would expose a missing bit of growth or a wrong sign extension as wrapped values. Back-to-back frames test the overwrite margin: a stage whose read run overlapped the next frame's writes would mix samples from two frames. Idle gaps, together with the exact 89-edge timing, would catch a read run that started early or late, or that ran longer than 32 cycles.

// File: rtl/wht_pkg.sv
package wht_pkg;
    // radix of the kernel and number of storage banks per stage (radix squared)
    localparam int RADIX = 2;
    localparam int BANKS = RADIX * RADIX;
endpackage

// File: rtl/wht_bfly.sv
module wht_bfly #(
    parameter int IW = 8
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [IW:0]   sum,
    output logic [IW:0]   dif
);
    // sign-extend both operands by one bit so neither result can wrap
    logic [IW:0] ax, bx;
    assign ax  = {a[IW-1], a};
    assign bx  = {b[IW-1], b};
    assign sum = ax + bx;
    assign dif = ax - bx;
endmodule

// File: rtl/wht_stage.sv
module wht_stage
    import wht_pkg::*;
#(
    parameter int IW    = 8,
    parameter int LOG_N = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [IW-1:0] in_data,
    output logic          out_valid,
    output logic          out_last,
    output logic [IW:0]   out_data
);
    localparam int N    = 1 << LOG_N;
    localparam int HALF = N / 2;
    localparam int QD   = N / BANKS;
    localparam int RW   = LOG_N - 2;
    localparam logic [LOG_N-1:0] LAST_IDX = LOG_N'(N - 1);
    localparam logic [LOG_N-1:0] MID_IDX  = LOG_N'(HALF);

    typedef struct packed {
        logic [LOG_N-1:0] wr_idx;
        logic             run;
        logic [LOG_N-1:0] rd_idx;
        logic             ov;
        logic             ol;
        logic [IW:0]      od;
        logic [IW:0]      hold;
    } st_t;

    st_t st_d, st_q;

    // write side: bank from address MSB and LSB, row from the middle bits
    logic [1:0]    wbank;
    logic [RW-1:0] wrow;
    assign wbank = {st_q.wr_idx[LOG_N-1], st_q.wr_idx[0]};
    assign wrow  = st_q.wr_idx[LOG_N-2:1];

    // read side: pair index i = rd_idx/2 addresses i and i+HALF
    logic [RW-1:0] rrow;
    logic          rlsb;
    assign rrow = st_q.rd_idx[LOG_N-1:2];
    assign rlsb = st_q.rd_idx[1];

    logic [IW-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [IW-1:0] q_mem [QD];
        always_ff @(posedge clk) begin
            if (in_valid && wbank == 2'(b)) q_mem[wrow] <= in_data;
        end
        assign bank_rd[b] = q_mem[rrow];
    end

    logic [IW-1:0] opa, opb;
    logic [IW:0]   sum, dif;
    assign opa = bank_rd[{1'b0, rlsb}];
    assign opb = bank_rd[{1'b1, rlsb}];

    wht_bfly #(.IW(IW)) u_bfly (.a(opa), .b(opb), .sum(sum), .dif(dif));

    logic start;
    assign start = in_valid && (st_q.wr_idx == MID_IDX);

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        if (in_valid) st_d.wr_idx = in_last ? '0 : st_q.wr_idx + 1'b1;
        if (st_q.run) begin
            st_d.ov = 1'b1;
            st_d.ol = (st_q.rd_idx == LAST_IDX);
            if (!st_q.rd_idx[0]) begin
                st_d.od   = sum;
                st_d.hold = dif;
            end else begin
                st_d.od = st_q.hold;
            end
            st_d.rd_idx = st_q.rd_idx + 1'b1;
            if (st_q.rd_idx == LAST_IDX) st_d.run = 1'b0;
        end
        if (start) begin
            st_d.run    = 1'b1;
            st_d.rd_idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_last  = st_q.ol;
    assign out_data  = st_q.od;

    // R2
    last_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> (st_q.wr_idx == LAST_IDX));

    // R4
    overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!st_q.run || st_q.rd_idx == LAST_IDX));

    // R3
    run_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov && !st_q.ol) |=> st_q.ov);

    // R2
    last_then_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ol |=> (!st_q.ov || st_q.rd_idx == LOG_N'(1)));
endmodule

// File: rtl/wht_stream.sv
module wht_stream #(
    parameter int DIN_W = 8,
    parameter int LOG_N = 5,
    localparam int DOUT_W = DIN_W + LOG_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DIN_W-1:0]  in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [DOUT_W-1:0] out_data
);
    // one identical stage per iteration; width grows by one bit per stage
    for (genvar s = 0; s < LOG_N; s++) begin : g_st
        logic [DIN_W+s-1:0] xin;
        logic               xv, xl;
        logic [DIN_W+s:0]   y;
        logic               v, l;

        if (s == 0) begin : g_first
            assign xin = in_data;
            assign xv  = in_valid;
            assign xl  = in_last;
        end else begin : g_next
            assign xin = g_st[s-1].y;
            assign xv  = g_st[s-1].v;
            assign xl  = g_st[s-1].l;
        end

        wht_stage #(.IW(DIN_W + s), .LOG_N(LOG_N)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (xv),
            .in_last  (xl),
            .in_data  (xin),
            .out_valid(v),
            .out_last (l),
            .out_data (y)
        );
    end

    assign out_valid = g_st[LOG_N-1].v;
    assign out_last  = g_st[LOG_N-1].l;
    assign out_data  = g_st[LOG_N-1].y;
endmodule

// File: tb/sim_wht_stream.sv
module sim_wht_stream;
    localparam int N   = 32;
    localparam int LAT = 89;   // five stages of 18 edges, less the capture edge

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_last;
    logic [12:0] out_data;

    always #5 clk = ~clk;

    wht_stream u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .out_valid(out_valid), .out_last(out_last),
        .out_data(out_data)
    );

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    int    tq[$];      // edge numbers of captured samples
    int    exp_q[$];   // expected coefficients in output order
    int    jq[$];      // coefficient index
    string tag_q[$];

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (in_valid) tq.push_back(cyc);
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            report();
            $finish;
        end
    end

    // reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                checks++;
                if (out_valid !== 1'b0 || out_last !== 1'b0) begin
                    errors++;
                    $display("FAIL R7 reset: got valid=%b last=%b expected 0 0", out_valid, out_last);
                end
            end else if (tq.size() > 0 && tq[0] + LAT == cyc) begin
                int e, j;
                string t;
                void'(tq.pop_front());
                e = exp_q.pop_front();
                j = jq.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (out_valid !== 1'b1) begin
                    errors++;
                    $display("FAIL R3 R4 valid coef %0d: got %b expected 1", j, out_valid);
                end
                checks++;
                if ($signed(out_data) != e) begin
                    errors++;
                    $display("FAIL %s coef %0d: got %0d expected %0d", t, j, $signed(out_data), e);
                end
                checks++;
                if (out_last !== (j == N - 1)) begin
                    errors++;
                    $display("FAIL R2 last coef %0d: got %b expected %b", j, out_last, (j == N - 1));
                end
            end else begin
                checks++;
                if (out_valid !== 1'b0 || out_last !== 1'b0) begin
                    errors++;
                    $display("FAIL R5 R7 idle cycle %0d: got valid=%b last=%b expected 0 0",
                             cyc, out_valid, out_last);
                end
            end
        end
    end

    task automatic send_frame(input int x[N], input string tag);
        for (int j = 0; j < N; j++) begin
            int s = 0;
            for (int k = 0; k < N; k++) begin
                if ($countones(j & k) % 2 == 1) s -= x[k];
                else                             s += x[k];
            end
            exp_q.push_back(s);
            jq.push_back(j);
            tag_q.push_back(tag);
        end
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(x[k]);
            in_last  = (k == N - 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            in_data  = '0;
        end
    endtask

    initial begin
        int fr[N];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        for (int k = 0; k < N; k++) fr[k] = k;
        send_frame(fr, "R1 ramp");
        idle(5);

        for (int k = 0; k < N; k++) fr[k] = (k == 0) ? 1 : 0;
        send_frame(fr, "R1 impulse0");
        idle(40);

        for (int k = 0; k < N; k++) fr[k] = (k == 7) ? -5 : 0;
        send_frame(fr, "R1 impulse7");
        // back to back from here on
        for (int k = 0; k < N; k++) fr[k] = -128;
        send_frame(fr, "R6 R4 min");
        for (int k = 0; k < N; k++) fr[k] = 127;
        send_frame(fr, "R6 R4 max");
        for (int k = 0; k < N; k++) fr[k] = (k % 2 == 0) ? 127 : -128;
        send_frame(fr, "R6 R4 alternating");
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < N; k++) fr[k] = int'($urandom_range(255)) - 128;
            send_frame(fr, "R1 R4 random");
        end
        idle(1);
        for (int k = 0; k < N; k++) fr[k] = N - 1 - k;
        send_frame(fr, "R1 falling ramp");
        idle(200);

        checks++;
        if (tq.size() != 0) begin
            errors++;
            $display("FAIL R3 drain: got %0d pending coefficients expected 0", tq.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule